// File: doc/BRIEF.md
# Synchronous Serial Status Flags

This block holds the interrupt status flags of a synchronous serial unit and guards its receive data register. The serial shifter reports its events as single-cycle strobes: a byte has arrived (with its data), the shifter has taken the next transmit byte, the last bit has left the shifter, or a bus conflict was seen. The block turns these strobes into five flags in an 8-bit status register. It keeps the last accepted receive byte. It drives four interrupt requests, each gated by an enable input.

A small CPU port gives access to three registers: status, receive data and transmit data. A flag that software clears must first be read as 1 from the status register and then written as 0. A byte that arrives while the receive-full flag is still set raises the overrun flag. Overrun freezes the held byte and raises a halt output that stops both directions until software clears it. Address 0 selects the status register, address 1 the receive data (read), address 2 the transmit data (write). Address 3 is unused.

Top module: `sercom_stat`

## Requirements
- R1: The status register has this layout: overrun at bit 6, transmit-end at bit 3, transmit-empty at bit 2, receive-full at bit 1 and conflict at bit 0. Bits 7, 5 and 4 always read as 0, and writes to them are ignored. After reset the status register is 0x04 and the held receive byte is 0x00.
- R2: A byte strobe that arrives while receive-full and overrun are both 0 stores the byte and sets receive-full; both are visible one cycle later. A CPU read of address 1 clears receive-full.
- R3: A byte strobe that arrives while receive-full is 1 and overrun is 0 sets overrun, and the held byte keeps its earlier value.
- R4: While overrun is 1, the halt output is 1 and the held byte does not change. Byte strobes, transmit-load strobes and shift-complete strobes have no effect on any flag.
- R5: A status flag clears only when the CPU writes 0 to its bit after a status read that saw the flag at 1. A 0 write without that read, or a write of 1, leaves the flag set. One read permits one clear.
- R6: If a flag's set event and a permitted clear fall in the same cycle, the flag stays 1.
- R7: A CPU write to address 2 clears transmit-empty. A transmit-load strobe sets transmit-empty. A shift-complete strobe sets transmit-end only while transmit-empty is 1.
- R8: A conflict strobe sets the conflict flag, which clears under the rule of R5.
- R9: The interrupt outputs are registered flags ANDed with enables: receive = receive-full AND rx_ie, overrun = overrun AND rx_ie, transmit = transmit-empty AND tx_ie, end = transmit-end AND tend_ie.
- R10: The read data follows the address in the same cycle: address 0 gives the status register, address 1 the held byte, and any other address gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Byte-received strobe from the shifter |
| rx_byte | input | 8 | Received byte, valid with rx_done |
| tx_load | input | 1 | Shifter has loaded the transmit byte |
| tx_shift_done | input | 1 | Last transmit bit shifted out |
| cfl_evt | input | 1 | Conflict strobe |
| reg_rd | input | 1 | CPU read strobe |
| reg_wr | input | 1 | CPU write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data |
| rx_ie | input | 1 | Receive and overrun interrupt enable |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| tend_ie | input | 1 | Transmit-end interrupt enable |
| status | output | 8 | Status register value |
| rx_hold | output | 8 | Held receive byte |
| xfer_halt | output | 1 | Stop transfers while overrun is pending |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_tend | output | 1 | Transmit-end interrupt request |

## Verification
Every flag, the held byte, the halt line and the interrupt requests change at the first clock edge after the strobe or CPU access that causes them. The read data follows the address and the held state within the same cycle. The bench drives its inputs one nanosecond after a rising edge. It advances its behavioural model on that edge from the same inputs the design sees. It compares all outputs at the falling edge that follows. Directed checks sample just after the edge that completes each pulse, so a result is never read before its register has loaded.

// File: rtl/sercom_stat_pkg.sv
package sercom_stat_pkg;

  localparam int STAT_W   = 8;
  localparam int NFLAG    = 5;
  localparam int ADDR_W   = 2;

  // flag slot order inside the generate array
  localparam int F_CE   = 0;
  localparam int F_RDRF = 1;
  localparam int F_TDRE = 2;
  localparam int F_TEND = 3;
  localparam int F_OVR  = 4;

  // slot values after reset: only transmit-empty starts set
  localparam logic [NFLAG-1:0] FLAG_RST = 5'b00100;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_RXD  = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status bit position of a flag slot
  function automatic int flag_pos(input int slot);
    return (slot == F_OVR) ? 6 : slot;
  endfunction

  // place flag slots into the status byte, reserved bits zero
  function automatic logic [STAT_W-1:0] pack_status(input logic [NFLAG-1:0] f);
    logic [STAT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NFLAG; i++) s[flag_pos(i)] = f[i];
    return s;
  endfunction

endpackage

// File: rtl/sercom_flag_cell.sv
module sercom_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic hw_clr,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wr_bit,
  output logic flag_q,
  output logic clr_ok
);

  logic arm_q;

  // a zero write clears only when a prior read saw this flag at 1
  assign clr_ok = stat_wr && !wr_bit && arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (set_evt)                flag_q <= 1'b1;
      else if (clr_ok || hw_clr)  flag_q <= 1'b0;
      arm_q <= (arm_q && flag_q && !clr_ok) || (stat_rd && flag_q);
    end
  end

endmodule

// File: rtl/sercom_rx_guard.sv
module sercom_rx_guard #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rdrf_q,
  input  logic              ovr_q,
  output logic              ev_accept,
  output logic              ev_overrun,
  output logic [DATA_W-1:0] hold_q
);

  assign ev_accept  = rx_done && !ovr_q && !rdrf_q;
  assign ev_overrun = rx_done && !ovr_q &&  rdrf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= '0;
    else if (ev_accept) hold_q <= rx_byte;
  end

endmodule

// File: rtl/sercom_tx_track.sv
module sercom_tx_track (
  input  logic tx_load,
  input  logic tx_shift_done,
  input  logic tdre_q,
  input  logic ovr_q,
  output logic ev_load,
  output logic ev_end
);

  assign ev_load = tx_load && !ovr_q;
  assign ev_end  = tx_shift_done && tdre_q && !ovr_q;

endmodule

// File: rtl/sercom_reg_dec.sv
module sercom_reg_dec
  import sercom_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [STAT_W-1:0]    status,
  input  logic [DATA_W-1:0]    hold,
  output logic                 stat_rd,
  output logic                 stat_wr,
  output logic                 rxd_rd,
  output logic                 txd_wr,
  output logic [DATA_W-1:0]    rdata
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  assign stat_rd = reg_rd && (sel == SEL_STAT);
  assign stat_wr = reg_wr && (sel == SEL_STAT);
  assign rxd_rd  = reg_rd && (sel == SEL_RXD);
  assign txd_wr  = reg_wr && (sel == SEL_TXD);

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_STAT: rdata[STAT_W-1:0] = status;
      SEL_RXD:  rdata = hold;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/sercom_stat.sv
module sercom_stat
  import sercom_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_load,
  input  logic              tx_shift_done,
  input  logic              cfl_evt,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_ie,
  input  logic              tx_ie,
  input  logic              tend_ie,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_hold,
  output logic              xfer_halt,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              irq_tx,
  output logic              irq_tend
);

  // named internal events, visible to the checker
  logic ev_stat_rd, ev_stat_wr, ev_rxd_rd, ev_txd_wr;
  logic ev_rx_accept, ev_rx_overrun, ev_tx_load, ev_tx_end;

  logic [NFLAG-1:0] flag_q, flag_set, flag_hclr, flag_clr_ok;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[7], reg_wdata[5:4]};

  sercom_reg_dec #(.DATA_W(DATA_W)) u_dec (
    .reg_rd  (reg_rd),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .status  (status),
    .hold    (rx_hold),
    .stat_rd (ev_stat_rd),
    .stat_wr (ev_stat_wr),
    .rxd_rd  (ev_rxd_rd),
    .txd_wr  (ev_txd_wr),
    .rdata   (reg_rdata)
  );

  sercom_rx_guard #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .rdrf_q    (flag_q[F_RDRF]),
    .ovr_q     (flag_q[F_OVR]),
    .ev_accept (ev_rx_accept),
    .ev_overrun(ev_rx_overrun),
    .hold_q    (rx_hold)
  );

  sercom_tx_track u_tx (
    .tx_load      (tx_load),
    .tx_shift_done(tx_shift_done),
    .tdre_q       (flag_q[F_TDRE]),
    .ovr_q        (flag_q[F_OVR]),
    .ev_load      (ev_tx_load),
    .ev_end       (ev_tx_end)
  );

  always_comb begin
    flag_set          = '0;
    flag_hclr         = '0;
    flag_set[F_CE]    = cfl_evt;
    flag_set[F_RDRF]  = ev_rx_accept;
    flag_hclr[F_RDRF] = ev_rxd_rd;
    flag_set[F_TDRE]  = ev_tx_load;
    flag_hclr[F_TDRE] = ev_txd_wr;
    flag_set[F_TEND]  = ev_tx_end;
    flag_set[F_OVR]   = ev_rx_overrun;
  end

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    sercom_flag_cell #(.RST_VAL(FLAG_RST[gi])) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(flag_set[gi]),
      .hw_clr (flag_hclr[gi]),
      .stat_rd(ev_stat_rd),
      .stat_wr(ev_stat_wr),
      .wr_bit (reg_wdata[flag_pos(gi)]),
      .flag_q (flag_q[gi]),
      .clr_ok (flag_clr_ok[gi])
    );
  end

  assign status    = pack_status(flag_q);
  assign xfer_halt = flag_q[F_OVR];
  assign irq_rx    = flag_q[F_RDRF] && rx_ie;
  assign irq_ovr   = flag_q[F_OVR]  && rx_ie;
  assign irq_tx    = flag_q[F_TDRE] && tx_ie;
  assign irq_tend  = flag_q[F_TEND] && tend_ie;

endmodule

// File: rtl/sercom_stat_chk.sv
module sercom_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic [7:0] rx_hold,
  input logic [7:0] rx_byte,
  input logic       rx_done,
  input logic       xfer_halt,
  input logic       irq_ovr,
  input logic       rx_ie,
  input logic       ev_rx_accept,
  input logic       ev_stat_rd,
  input logic       ev_stat_wr,
  input logic [7:0] reg_wdata
);

  // tracks whether overrun has been read as 1 since it last rose
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (!status[6]) seen_q <= 1'b0;
    else if (ev_stat_rd) seen_q <= 1'b1;
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == 1'b0) && (status[5:4] == 2'b00));

  a_r2_accept_stores: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_accept |=> (status[1] && rx_hold == $past(rx_byte)));

  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status[1] && !status[6]) |=> status[6]);

  a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |=> $stable(rx_hold));

  a_r4_halt_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_halt == status[6]);

  a_r5_no_blind_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && ev_stat_wr && !reg_wdata[6] && !seen_q) |=> status[6]);

  a_r9_irq_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr == (status[6] && rx_ie));

endmodule

bind sercom_stat sercom_stat_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status      (status),
  .rx_hold     (rx_hold),
  .rx_byte     (rx_byte),
  .rx_done     (rx_done),
  .xfer_halt   (xfer_halt),
  .irq_ovr     (irq_ovr),
  .rx_ie       (rx_ie),
  .ev_rx_accept(ev_rx_accept),
  .ev_stat_rd  (ev_stat_rd),
  .ev_stat_wr  (ev_stat_wr),
  .reg_wdata   (reg_wdata)
);

// File: tb/sercom_stat_tb.sv
`timescale 1ns/1ps
module sercom_stat_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, tx_load = 0, tx_shift_done = 0, cfl_evt = 0;
  logic [7:0] rx_byte = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic rx_ie = 0, tx_ie = 0, tend_ie = 0;
  logic [7:0] reg_rdata, status, rx_hold;
  logic xfer_halt, irq_rx, irq_ovr, irq_tx, irq_tend;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sercom_stat u_dut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_shift_done(tx_shift_done), .cfl_evt(cfl_evt),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_ie(rx_ie),
    .tx_ie(tx_ie), .tend_ie(tend_ie), .status(status), .rx_hold(rx_hold),
    .xfer_halt(xfer_halt), .irq_rx(irq_rx), .irq_ovr(irq_ovr),
    .irq_tx(irq_tx), .irq_tend(irq_tend)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] m_stat, m_arm, m_hold;
  logic [7:0] m_set, m_hclr, m_next;
  int flag_bits[5] = '{0, 1, 2, 3, 6};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 8'h04; m_arm = 8'h00; m_hold = 8'h00;
    end else begin
      m_set = 0; m_hclr = 0; m_next = m_stat;
      if (rx_done && !m_stat[6]) begin
        if (m_stat[1]) m_set[6] = 1;
        else begin m_set[1] = 1; m_hold = rx_byte; end
      end
      if (reg_rd && reg_addr == 2'd1) m_hclr[1] = 1;
      if (tx_load && !m_stat[6]) m_set[2] = 1;
      if (reg_wr && reg_addr == 2'd2) m_hclr[2] = 1;
      if (tx_shift_done && m_stat[2] && !m_stat[6]) m_set[3] = 1;
      if (cfl_evt) m_set[0] = 1;
      foreach (flag_bits[k]) begin
        automatic int b = flag_bits[k];
        automatic bit allow = reg_wr && reg_addr == 2'd0 && !reg_wdata[b] && m_arm[b];
        if (m_set[b]) m_next[b] = 1;
        else if (allow || m_hclr[b]) m_next[b] = 0;
        m_arm[b] = (m_arm[b] && m_stat[b] && !allow) ||
                   (reg_rd && reg_addr == 2'd0 && m_stat[b]);
      end
      m_stat = m_next;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [7:0] exp_rd = (reg_addr == 2'd0) ? m_stat :
                                     (reg_addr == 2'd1) ? m_hold : 8'h00;
      chk("R1", "reserved bits", {status[7], status[5:4]}, 0);
      chk("R2", "receive-full", status[1], m_stat[1]);
      chk("R2", "held byte", rx_hold, m_hold);
      chk("R3", "overrun", status[6], m_stat[6]);
      chk("R4", "halt", xfer_halt, m_stat[6]);
      chk("R7", "transmit-empty", status[2], m_stat[2]);
      chk("R7", "transmit-end", status[3], m_stat[3]);
      chk("R8", "conflict", status[0], m_stat[0]);
      chk("R9", "irq vector", {irq_rx, irq_ovr, irq_tx, irq_tend},
          {m_stat[1] & rx_ie, m_stat[6] & rx_ie, m_stat[2] & tx_ie, m_stat[3] & tend_ie});
      chk("R10", "read data", reg_rdata, exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rx_pulse(input logic [7:0] b);
    rx_done = 1; rx_byte = b; step(); rx_done = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    reg_rd = 1; reg_addr = a; step(); reg_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", "reset status", status, 8'h04);
    chk("R1", "reset held byte", rx_hold, 8'h00);

    rx_pulse(8'hA5);
    chk("R2", "rdrf after byte", status[1], 1);
    chk("R2", "stored byte", rx_hold, 8'hA5);
    reg_addr = 2'd1; #1;
    chk("R10", "rx data read", reg_rdata, 8'hA5);
    rd(2'd1);
    chk("R2", "rdrf cleared by read", status[1], 0);

    rx_pulse(8'h11);
    rx_pulse(8'h22);
    chk("R3", "overrun set", status[6], 1);
    chk("R3", "older byte kept", rx_hold, 8'h11);
    chk("R4", "halt raised", xfer_halt, 1);
    rx_pulse(8'h33);
    chk("R4", "later byte dropped", rx_hold, 8'h11);
    wr(2'd2, 8'h5A);
    chk("R7", "tdre cleared by tx write", status[2], 0);
    tx_load = 1; step(); tx_load = 0;
    chk("R4", "load ignored in overrun", status[2], 0);

    wr(2'd0, 8'h00);
    chk("R5", "blind zero write", status[6], 1);
    rd(2'd0);
    wr(2'd0, 8'h40);
    chk("R5", "write of one", status[6], 1);
    wr(2'd0, 8'hBF);
    chk("R5", "armed clear", status[6], 0);
    chk("R4", "halt released", xfer_halt, 0);

    tx_load = 1; step(); tx_load = 0;
    chk("R7", "tdre set by load", status[2], 1);
    tx_shift_done = 1; step(); tx_shift_done = 0;
    chk("R7", "tend set", status[3], 1);
    rd(2'd0);
    wr(2'd0, 8'hF7);
    chk("R5", "tend cleared", status[3], 0);
    wr(2'd2, 8'h00);
    tx_shift_done = 1; step(); tx_shift_done = 0;
    chk("R7", "tend needs tdre", status[3], 0);

    cfl_evt = 1; step(); cfl_evt = 0;
    chk("R8", "conflict set", status[0], 1);
    rd(2'd0);
    cfl_evt = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'hFE;
    step(); cfl_evt = 0; reg_wr = 0;
    chk("R6", "set beats clear", status[0], 1);
    rd(2'd0);
    wr(2'd0, 8'hFE);
    chk("R8", "conflict cleared", status[0], 0);

    wr(2'd0, 8'hFF);
    chk("R1", "reserved write ignored", {status[7], status[5:4]}, 0);

    rx_ie = 1; tx_ie = 1; tend_ie = 1; #1;
    chk("R9", "irq_rx", irq_rx, status[1]);
    rx_pulse(8'h77);
    rx_pulse(8'h88);
    chk("R9", "irq_ovr", irq_ovr, 1);
    rx_ie = 0; #1;
    chk("R9", "irq_ovr masked", irq_ovr, 0);

    reg_addr = 2'd3; #1;
    chk("R10", "unused address", reg_rdata, 0);
    reg_addr = 2'd0; #1;
    chk("R10", "status read data", reg_rdata, status);

    repeat (10) step();
    finish_run();
  end

endmodule